// File: doc/BRIEF.md
# Sequential Dial Lock Controller

This block is a synchronous state machine that releases a lock only after three dial operations arrive in the correct order. Each operation is a single event made of a turn direction and a 6-bit dial position, marked by a one-cycle valid strobe. The machine records every correct step as its own state, so the order of the operations matters and not just the set of positions. A wrong operation sends the machine back to the start. The one exception is a wrong operation that is itself a correct opening move: it counts as the first step.

The combination is fixed when the design is elaborated. Three value and direction parameter pairs set it, and their defaults are right to 13, then left to 22, then right to 3. Once the lock is open it ignores further dial operations. Only a relock pulse or reset closes it. The operation input uses a valid/ready handshake. The block accepts an operation in every cycle, so the ready output is always high and the block never applies back-pressure. An operation counts in the cycle where valid is high, and the sender never needs to hold it.

Top module: `dial_lock`

## Requirements
- R1: A synchronous active-high reset puts the machine in the idle state. After the first clock edge with reset high, the state output reads 2'b00 and the open output is low.
- R2: The state output encodes the four states as 2'b00 idle, 2'b01 first step done, 2'b10 two steps done and 2'b11 open.
- R3: The open output is high in state 2'b11 and low in every other state.
- R4: A direction bit of 0 means right and 1 means left. With the default parameters, the accepted operations right 13, left 22 and right 3 move the state through 01, 10 and 11. Each state change appears after the rising edge at which its operation is accepted.
- R5: The state does not change in a cycle where valid is low, whatever the direction and value inputs hold.
- R6: In state 01 or 10, an operation with the wrong value returns the machine to idle.
- R7: In any state other than open, an operation with the right value but the wrong direction is not accepted as progress. In state 01 or 10 it returns the machine to idle, and in idle the machine stays idle.
- R8: In state 01 or 10, a wrong operation that matches the first step of the combination moves the machine to state 01.
- R9: In the open state, valid operations have no effect, including a repeat of the first step.
- R10: A relock pulse moves the machine to idle from any state at the next rising edge, and it takes priority over a valid operation in the same cycle.
- R11: The ready output is high in every cycle after reset, so every operation presented with valid high is consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle strobe marking a dial operation |
| op_ready | output | 1 | Always high; the block never stalls |
| op_dir | input | 1 | Turn direction: 0 right, 1 left |
| op_val | input | 6 | Dial position of the operation |
| relock | input | 1 | Close the lock and return to idle |
| open_o | output | 1 | High while the lock is open |
| st_code | output | 2 | Current state code |

## Verification
Every result of this block is due one rising edge after its cause. An operation or relock is driven at a falling edge, is captured at the next rising edge, and is visible on the state and open outputs before the following falling edge. The bench therefore drives each stimulus on a falling edge and compares the outputs at the next falling edge, half a period after the register has updated. The hold and ignore cases keep their inputs steady for several cycles and compare the outputs at each falling edge, so that a late change is caught as well as an immediate one.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int unsigned NUM_STEPS = 3;
  localparam logic DIR_RIGHT = 1'b0;
  localparam logic DIR_LEFT  = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_OPEN = 2'b11
  } lock_state_t;
endpackage

// File: rtl/dial_step_match.sv
module dial_step_match
  import lock_pkg::*;
#(
  parameter int unsigned VAL_W = 6,
  parameter logic [VAL_W-1:0] STEP0_VAL = 13,
  parameter logic [VAL_W-1:0] STEP1_VAL = 22,
  parameter logic [VAL_W-1:0] STEP2_VAL = 3,
  parameter logic STEP0_DIR = DIR_RIGHT,
  parameter logic STEP1_DIR = DIR_LEFT,
  parameter logic STEP2_DIR = DIR_RIGHT
) (
  input  logic                 op_dir,
  input  logic [VAL_W-1:0]     op_val,
  output logic [NUM_STEPS-1:0] hit
);
  localparam logic [NUM_STEPS*VAL_W-1:0] VALS = {STEP2_VAL, STEP1_VAL, STEP0_VAL};
  localparam logic [NUM_STEPS-1:0]       DIRS = {STEP2_DIR, STEP1_DIR, STEP0_DIR};

  // One comparator per combination step
  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
    assign hit[i] = (op_val == VALS[i*VAL_W +: VAL_W]) && (op_dir == DIRS[i]);
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [NUM_STEPS-1:0] hit,
  input  logic                 relock,
  output lock_state_t          state
);
  lock_state_t state_nx;

  always_comb begin
    state_nx = state;
    if (relock) begin
      state_nx = ST_IDLE;
    end else if (op_valid) begin
      unique case (state)
        ST_IDLE: state_nx = hit[0] ? ST_ONE : ST_IDLE;
        ST_ONE:  state_nx = hit[1] ? ST_TWO  : (hit[0] ? ST_ONE : ST_IDLE);
        ST_TWO:  state_nx = hit[2] ? ST_OPEN : (hit[0] ? ST_ONE : ST_IDLE);
        ST_OPEN: state_nx = ST_OPEN;
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> state == ST_IDLE);

  assert_hold_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !relock) |=> $stable(state));

  assert_idle_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && op_valid && !relock && !hit[0]) |=> state == ST_IDLE);

  assert_first_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_OPEN && op_valid && !relock && hit[0] && !(state == ST_ONE && hit[1]))
    |=> state == ST_ONE);

  assert_open_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPEN && !relock) |=> state == ST_OPEN);

  assert_relock_idle_R10: assert property (@(posedge clk) disable iff (rst)
    relock |=> state == ST_IDLE);
endmodule

// File: rtl/dial_lock.sv
module dial_lock
  import lock_pkg::*;
#(
  parameter int unsigned VAL_W = 6,
  parameter logic [VAL_W-1:0] STEP0_VAL = 13,
  parameter logic [VAL_W-1:0] STEP1_VAL = 22,
  parameter logic [VAL_W-1:0] STEP2_VAL = 3,
  parameter logic STEP0_DIR = DIR_RIGHT,
  parameter logic STEP1_DIR = DIR_LEFT,
  parameter logic STEP2_DIR = DIR_RIGHT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_dir,
  input  logic [VAL_W-1:0] op_val,
  input  logic             relock,
  output logic             open_o,
  output logic [1:0]       st_code
);
  logic [NUM_STEPS-1:0] step_hit;
  lock_state_t          state;

  dial_step_match #(
    .VAL_W(VAL_W),
    .STEP0_VAL(STEP0_VAL), .STEP1_VAL(STEP1_VAL), .STEP2_VAL(STEP2_VAL),
    .STEP0_DIR(STEP0_DIR), .STEP1_DIR(STEP1_DIR), .STEP2_DIR(STEP2_DIR)
  ) u_match (
    .op_dir(op_dir),
    .op_val(op_val),
    .hit   (step_hit)
  );

  lock_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .op_valid(op_valid),
    .hit     (step_hit),
    .relock  (relock),
    .state   (state)
  );

  assign op_ready = 1'b1;
  assign st_code  = state;
  assign open_o   = (state == ST_OPEN);

  assert_open_via_last_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(st_code) == 2'b10);

  assert_ready_high_R11: assert property (@(posedge clk) disable iff (rst) op_ready);
endmodule

// File: tb/dial_lock_tb.sv
module dial_lock_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic       op_dir = 1'b0;
  logic [5:0] op_val = '0;
  logic       relock = 1'b0;
  logic       open_o;
  logic [1:0] st_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic R = 1'b0;
  localparam logic L = 1'b1;

  always #4 clk = ~clk;

  dial_lock u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_dir(op_dir), .op_val(op_val), .relock(relock),
    .open_o(open_o), .st_code(st_code)
  );

  task automatic check(input string req, input logic [1:0] exp_st);
    logic exp_open;
    exp_open = (exp_st == 2'b11);
    checks++;
    if (st_code !== exp_st || open_o !== exp_open) begin
      errors++;
      $display("FAIL %s: state %b open %b, expected state %b open %b",
               req, st_code, open_o, exp_st, exp_open);
    end
  endtask

  // Present one operation for one cycle; returns at the falling edge after capture
  task automatic op(input logic d, input logic [5:0] v);
    @(negedge clk);
    op_valid = 1'b1; op_dir = d; op_val = v;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_relock();
    @(negedge clk);
    relock = 1'b1;
    @(negedge clk);
    relock = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset", 2'b00);
  endtask

  task automatic t_open_seq();
    t_reset();
    op(R, 13); check("R2 R4 first step", 2'b01);
    op(L, 22); check("R2 R4 second step", 2'b10);
    op(R, 3);  check("R3 R4 open", 2'b11);
  endtask

  task automatic t_hold();
    t_reset();
    op(R, 13);
    @(negedge clk);
    op_dir = L; op_val = 22;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R5 hold without valid", 2'b01);
    end
  endtask

  task automatic t_wrong_value();
    t_reset();
    op(R, 13); op(L, 21); check("R6 wrong value step two", 2'b00);
    op(R, 13); op(L, 22); op(R, 4); check("R6 wrong value step three", 2'b00);
  endtask

  task automatic t_wrong_dir();
    t_reset();
    op(L, 13); check("R7 wrong dir in idle", 2'b00);
    op(R, 13); op(R, 22); check("R7 wrong dir step two", 2'b00);
    op(R, 13); op(L, 22); op(L, 3); check("R7 wrong dir step three", 2'b00);
  endtask

  task automatic t_restart();
    t_reset();
    op(R, 13); op(R, 13); check("R8 repeat first in state one", 2'b01);
    op(L, 22); op(R, 13); check("R8 first step in state two", 2'b01);
    op(L, 22); op(R, 3); check("R8 continue after restart", 2'b11);
  endtask

  task automatic t_open_ignore();
    t_open_seq();
    op(L, 0);  check("R9 open ignores wrong op", 2'b11);
    op(R, 13); check("R9 open ignores first step", 2'b11);
    op(R, 3);  check("R9 open ignores last step", 2'b11);
  endtask

  task automatic t_relock();
    t_open_seq();
    do_relock(); check("R10 relock from open", 2'b00);
    op(R, 13); op(L, 22);
    @(negedge clk);
    relock = 1'b1; op_valid = 1'b1; op_dir = R; op_val = 3;
    @(negedge clk);
    relock = 1'b0; op_valid = 1'b0;
    check("R10 relock beats valid", 2'b00);
    op(R, 13); do_relock(); check("R10 relock from state one", 2'b00);
  endtask

  task automatic t_ready();
    t_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (op_ready !== 1'b1) begin
        errors++;
        $display("FAIL R11 ready: got %b expected 1", op_ready);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_open_seq();
    t_hold();
    t_wrong_value();
    t_wrong_dir();
    t_restart();
    t_open_ignore();
    t_relock();
    t_ready();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule